// File: doc/BRIEF.md
# Scatter-Gather Descriptor Loader

This block chains transfer descriptors for one DMA channel. When the channel's major loop finishes, it reports completion, and it can raise an interrupt when the finishing descriptor asks for one. If that descriptor has chaining enabled, the block treats the descriptor's end-of-major adjustment field as the memory address of the next descriptor. It then reads the next descriptor from memory and writes it into the channel's active descriptor registers. Software takes no part in this.

A descriptor is eight 32-bit words, read one word at a time from an address aligned to 32 bytes. Word 7 is the control word, and bit 0 of it is the start bit. Words are written into the active registers as they arrive, so the control word is written last. It is written with its start bit cleared. One cycle later, a separate go pulse asks the engine to begin the new major loop, but only if the fetched start bit was 1. Otherwise the channel waits for a hardware request. If the next address is misaligned, nothing is fetched and an error flag is raised. While a load is in progress, the loader is busy and ignores further major-done pulses.

Top module: `sg_desc_loader`

## Requirements
- R1: After reset, busy, fin, irq, err, go, load_done, mem_rd and desc_we are all 0.
- R2: A major_done accepted with sg_en=1 and next_desc[4:0]=0 issues exactly 8 reads. Read i goes to next_desc + 4*i, for i = 0 to 7 in order, with one read outstanding at a time.
- R3: Each read response produces one desc_we pulse in the next cycle, with desc_idx = i and desc_wdata equal to the returned word. Index 7 (the control word) is written last, and its bit 0 (the start bit) is forced to 0.
- R4: One cycle after the index-7 write, load_done pulses and busy falls. go pulses in that same cycle only if bit 0 of the fetched word 7 was 1.
- R5: Every accepted major_done pulses fin in the next cycle. irq pulses in that same cycle exactly when int_en was 1.
- R6: With sg_en=0, an accepted major_done gives only fin (and irq). No read or write happens, and busy stays 0.
- R7: With sg_en=1 and next_desc[4:0] not 0, no read or write happens and err is set. err stays set until the next accepted major_done clears it.
- R8: A major_done that arrives while busy=1 is ignored. It causes no fin, no irq and no change to err, and the load in progress completes unchanged.
- R9: The completion flag comes before the load. fin pulses exactly one cycle before the first read of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| major_done_i | input | 1 | Major loop of the active descriptor finished (pulse) |
| sg_en_i | input | 1 | Chaining enable of the active descriptor |
| int_en_i | input | 1 | Completion-interrupt enable of the active descriptor |
| next_desc_i | input | 32 | Next-descriptor address field of the active descriptor |
| mem_rd_o | output | 1 | Word read request (one cycle) |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| desc_we_o | output | 1 | Active descriptor word write strobe |
| desc_idx_o | output | 3 | Index of the word being written |
| desc_wdata_o | output | 32 | Word written |
| busy_o | output | 1 | Load in progress; new major loops are held off |
| fin_o | output | 1 | Completion flag of the finished descriptor (pulse) |
| irq_o | output | 1 | Completion interrupt (pulse) |
| err_o | output | 1 | Misaligned next-descriptor address (sticky) |
| go_o | output | 1 | Start the newly loaded descriptor (pulse) |
| load_done_o | output | 1 | Descriptor load complete (pulse) |

## Verification
Timing is counted in cycles after the edge that samples major_done. fin and irq are due one cycle later, and the first read one cycle after fin. Each write is due one cycle after its read response, and go with load_done one cycle after the last write. The bench sweeps memory latency from 1 to 3 cycles together with every combination of start bit and interrupt enable, plus several misaligned offsets. A monitor sampling on the falling edge records every read, write and pulse with its cycle number. After busy falls, the records are compared with values the bench computes from the address.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLAG  = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_GO    = 3'd4
    } sgl_state_e;
endpackage

// File: rtl/sgl_align_chk.sv
module sgl_align_chk #(
    parameter int AW     = 32,
    parameter int ALIGNB = 5
) (
    input  logic [AW-1:0] addr_i,
    output logic          ok_o
);
    assign ok_o = (addr_i[ALIGNB-1:0] == '0);
endmodule

// File: rtl/sgl_start_mask.sv
module sgl_start_mask #(
    parameter int DW     = 32,
    parameter int ST_BIT = 0
) (
    input  logic [DW-1:0] word_i,
    input  logic          ctrl_i,
    output logic [DW-1:0] word_o,
    output logic          start_o
);
    always_comb begin
        word_o = word_i;
        if (ctrl_i) begin
            word_o[ST_BIT] = 1'b0;
        end
    end
    assign start_o = word_i[ST_BIT];
endmodule

// File: rtl/sg_desc_loader.sv
module sg_desc_loader #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int NWORDS = 8,
    parameter int ST_BIT = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          major_done_i,
    input  logic                          sg_en_i,
    input  logic                          int_en_i,
    input  logic [AW-1:0]                 next_desc_i,
    output logic                          mem_rd_o,
    output logic [AW-1:0]                 mem_addr_o,
    input  logic [DW-1:0]                 mem_rdata_i,
    input  logic                          mem_rvalid_i,
    output logic                          desc_we_o,
    output logic [$clog2(NWORDS)-1:0]     desc_idx_o,
    output logic [DW-1:0]                 desc_wdata_o,
    output logic                          busy_o,
    output logic                          fin_o,
    output logic                          irq_o,
    output logic                          err_o,
    output logic                          go_o,
    output logic                          load_done_o
);
    import sgl_pkg::*;

    localparam int IW     = $clog2(NWORDS);
    localparam int BSH    = $clog2(DW / 8);
    localparam int ALIGNB = $clog2(NWORDS * DW / 8);
    localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

    typedef struct packed {
        sgl_state_e     st;
        logic [IW-1:0]  idx;
        logic [AW-1:0]  base;
        logic           fin;
        logic           irq;
        logic           err;
        logic           we;
        logic [IW-1:0]  widx;
        logic [DW-1:0]  wdata;
        logic           start;
        logic           go;
        logic           ldone;
    } sgl_regs_t;

    sgl_regs_t r_d, r_q;

    logic          addr_ok;
    logic          is_ctrl;
    logic [DW-1:0] word_masked;
    logic          word_start;

    sgl_align_chk #(.AW(AW), .ALIGNB(ALIGNB)) u_align (
        .addr_i (next_desc_i),
        .ok_o   (addr_ok)
    );

    assign is_ctrl = (r_q.idx == LAST);

    sgl_start_mask #(.DW(DW), .ST_BIT(ST_BIT)) u_mask (
        .word_i  (mem_rdata_i),
        .ctrl_i  (is_ctrl),
        .word_o  (word_masked),
        .start_o (word_start)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fin   = 1'b0;
        r_d.irq   = 1'b0;
        r_d.we    = 1'b0;
        r_d.go    = 1'b0;
        r_d.ldone = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (major_done_i) begin
                    r_d.fin = 1'b1;
                    r_d.irq = int_en_i;
                    r_d.err = 1'b0;
                    if (sg_en_i) begin
                        if (addr_ok) begin
                            r_d.st   = ST_FLAG;
                            r_d.base = next_desc_i;
                            r_d.idx  = '0;
                        end else begin
                            r_d.err = 1'b1;
                        end
                    end
                end
            end
            ST_FLAG:  r_d.st = ST_FETCH;
            ST_FETCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    r_d.we    = 1'b1;
                    r_d.widx  = r_q.idx;
                    r_d.wdata = word_masked;
                    if (is_ctrl) begin
                        r_d.start = word_start;
                        r_d.st    = ST_GO;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            ST_GO: begin
                r_d.go    = r_q.start;
                r_d.ldone = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_o     = (r_q.st == ST_FETCH);
    assign mem_addr_o   = r_q.base + (AW'(r_q.idx) << BSH);
    assign desc_we_o    = r_q.we;
    assign desc_idx_o   = r_q.widx;
    assign desc_wdata_o = r_q.wdata;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign fin_o        = r_q.fin;
    assign irq_o        = r_q.irq;
    assign err_o        = r_q.err;
    assign go_o         = r_q.go;
    assign load_done_o  = r_q.ldone;
endmodule

// File: rtl/sgl_checker.sv
module sgl_checker #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          major_done_i,
    input logic          mem_rd_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          desc_we_o,
    input logic [IW-1:0] desc_idx_o,
    input logic [DW-1:0] desc_wdata_o,
    input logic          busy_o,
    input logic          fin_o,
    input logic          irq_o,
    input logic          err_o,
    input logic          go_o,
    input logic          load_done_o
);
    // R2: reads are word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o[1:0] == 2'b00));
    // R2: one read outstanding, never two in a row
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);
    // R3: control word written with start bit cleared
    a_r3_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we_o && desc_idx_o == IW'(2**IW - 1)) |-> !desc_wdata_o[0]);
    // R4: go only together with load completion
    a_r4_go_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> load_done_o);
    // R4: load completion follows a write
    a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> ($past(desc_we_o) && !busy_o));
    // R5: irq only with fin
    a_r5_irq_with_fin: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> fin_o);
    // R6: no writes when idle
    a_r6_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we_o |-> busy_o);
    // R7: error state never fetches
    a_r7_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_rd_o);
    // R8: no completion flag while a load runs
    a_r8_busy_no_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && major_done_i) |=> !fin_o);
    // R9: fin is followed by the first read when a load starts
    a_r9_fin_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && busy_o) |=> mem_rd_o);
endmodule

bind sg_desc_loader sgl_checker #(.AW(AW), .DW(DW), .IW($clog2(NWORDS))) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .major_done_i (major_done_i),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .desc_we_o    (desc_we_o),
    .desc_idx_o   (desc_idx_o),
    .desc_wdata_o (desc_wdata_o),
    .busy_o       (busy_o),
    .fin_o        (fin_o),
    .irq_o        (irq_o),
    .err_o        (err_o),
    .go_o         (go_o),
    .load_done_o  (load_done_o)
);

// File: tb/sim_sg_desc_loader.sv
`timescale 1ns/1ps
module sim_sg_desc_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        major_done = 1'b0, sg_en = 1'b0, int_en = 1'b0;
    logic [31:0] next_desc = '0;
    logic        mem_rd, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        desc_we, busy, fin, irq, err, go, ldone;
    logic [2:0]  desc_idx;
    logic [31:0] desc_wdata;

    always #10 clk = ~clk;

    sg_desc_loader u0 (
        .clk(clk), .rst_n(rst_n), .major_done_i(major_done), .sg_en_i(sg_en),
        .int_en_i(int_en), .next_desc_i(next_desc), .mem_rd_o(mem_rd),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid),
        .desc_we_o(desc_we), .desc_idx_o(desc_idx), .desc_wdata_o(desc_wdata),
        .busy_o(busy), .fin_o(fin), .irq_o(irq), .err_o(err), .go_o(go),
        .load_done_o(ldone)
    );

    int checks = 0, errors = 0;
    int lat = 1;
    logic tb_start = 1'b0;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        logic [31:0] w;
        w = (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
        if (a[4:2] == 3'd7) w[0] = tb_start;
        return w;
    endfunction

    // memory model: answers each read after lat cycles
    logic [3:0]  pv;
    logic [31:0] pa [4];
    always_ff @(posedge clk) begin
        pv <= {pv[2:0], mem_rd};
        pa[0] <= mem_addr;
        pa[1] <= pa[0];
        pa[2] <= pa[1];
        pa[3] <= pa[2];
    end
    assign mem_rvalid = pv[lat-1];
    assign mem_rdata  = mdata(pa[lat-1]);

    // monitor
    int cyc = 0;
    int n_fin, n_irq, n_rd, n_wr, n_go, n_ld, bad_rd, bad_wr, fin_cyc, rd_cyc;
    logic [31:0] base;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (fin) begin n_fin <= n_fin + 1; fin_cyc <= cyc; end
            if (irq) n_irq <= n_irq + 1;
            if (go) n_go <= n_go + 1;
            if (ldone) n_ld <= n_ld + 1;
            if (mem_rd) begin
                if (n_rd == 0) rd_cyc <= cyc;
                if (mem_addr != base + 32'(n_rd * 4)) bad_rd <= bad_rd + 1;
                n_rd <= n_rd + 1;
            end
            if (desc_we) begin
                logic [31:0] e;
                e = mdata(base + 32'(n_wr * 4));
                if (n_wr == 7) e[0] = 1'b0;
                if (desc_idx != 3'(n_wr) || desc_wdata != e) bad_wr <= bad_wr + 1;
                n_wr <= n_wr + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        n_fin = 0; n_irq = 0; n_rd = 0; n_wr = 0; n_go = 0; n_ld = 0;
        bad_rd = 0; bad_wr = 0; fin_cyc = -10; rd_cyc = -10;
    endtask

    task automatic pulse(input logic sg, input logic ie, input logic [31:0] a);
        sg_en = sg; int_en = ie; next_desc = a;
        major_done = 1'b1;
        @(negedge clk);
        major_done = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input logic sg, input logic ie, input logic [31:0] a,
                       input logic st, input int l);
        logic loads;
        lat = l; tb_start = st; base = a;
        clr();
        pulse(sg, ie, a);
        settle();
        loads = sg && (a[4:0] == 5'd0);
        chk("R5 fin count", n_fin, 1);
        chk("R5 irq count", n_irq, int'(ie));
        if (loads) begin
            chk("R2 read count", n_rd, 8);
            chk("R2 read addresses", bad_rd, 0);
            chk("R3 write count", n_wr, 8);
            chk("R3 write idx/data", bad_wr, 0);
            chk("R4 load_done count", n_ld, 1);
            chk("R4 go count", n_go, int'(st));
            chk("R9 fin one cycle before first read", rd_cyc - fin_cyc, 1);
            chk("R7 err clear", int'(err), 0);
        end else begin
            chk(sg ? "R7 no reads" : "R6 no reads", n_rd, 0);
            chk(sg ? "R7 no writes" : "R6 no writes", n_wr, 0);
            chk("R6 no load_done", n_ld + n_go, 0);
            chk("R7 err flag", int'(err), int'(sg));
        end
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({busy, fin, irq, err, go, ldone, mem_rd, desc_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(busy), 0);

        for (int l = 1; l <= 3; l++)
            for (int st = 0; st < 2; st++)
                for (int ie = 0; ie < 2; ie++)
                    run(1'b1, 1'(ie), 32'h1000_0000 + 32'(l * 256 + st * 64 + ie * 32),
                        1'(st), l);

        run(1'b0, 1'b1, 32'h2000_0000, 1'b1, 1);   // R6
        run(1'b0, 1'b0, 32'h2000_0004, 1'b0, 1);   // R6 misaligned ignored
        run(1'b1, 1'b0, 32'h3000_0004, 1'b1, 2);   // R7
        repeat (5) @(negedge clk);
        chk("R7 err sticky", int'(err), 1);
        run(1'b1, 1'b1, 32'h3000_0010, 1'b0, 1);   // R7
        run(1'b1, 1'b0, 32'h3000_0001, 1'b0, 1);   // R7
        run(1'b1, 1'b1, 32'h3000_0040, 1'b1, 1);   // R7 cleared by accepted major_done

        // R8: major_done during busy is ignored
        lat = 3; tb_start = 1'b1; base = 32'h4000_0020;
        clr();
        pulse(1'b1, 1'b0, 32'h4000_0020);
        repeat (4) @(negedge clk);
        chk("R8 busy during load", int'(busy), 1);
        pulse(1'b1, 1'b1, 32'h4000_0003);
        settle();
        chk("R8 single fin", n_fin, 1);
        chk("R8 no irq", n_irq, 0);
        chk("R8 err untouched", int'(err), 0);
        chk("R8 load completes", n_wr + bad_wr + bad_rd, 8);
        chk("R8 go", n_go, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule